// File: doc/BRIEF.md
# Multiplexed BCD Display Refresh Controller

This block keeps sixteen 8-bit display entries and refreshes a bank of multiplexed digits with no help from the host. A free-running 4-bit scan count selects one digit at a time. The low nibble of the selected entry is driven as BCD on a 4-bit bus that stays aligned with the scan. Each digit slot starts with a blanked interval, where the bus shows 0xF, so the old digit does not ghost onto the newly selected position. The nibble is captured once per slot, so a write from the host never tears the displayed value.

The host writes through one valid/ready port that carries both commands and data. A transfer takes place on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the host holds `wr_valid`, `wr_is_cmd` and `wr_data` steady. `wr_ready` goes low only while a clear command is sweeping the storage.

A command selects one of two entry modes or clears the storage. In right-entry mode, which resembles a calculator, each new digit lands in the rightmost position and the older digits move one place left. In left-entry mode, each digit goes to an auto-incrementing address.

Top module: `bcd_scan_display`

## Requirements
- R1: After reset, all 16 entries hold 0xFF, so every digit shows 0xF (blank). The scan count is 0 and the mode is right-entry.
- R2: The scan output steps by +1 modulo 16 once every TICK_DIV*SLOT_TICKS clock cycles, and never changes in any other way.
- R3: For the first TICK_DIV clock cycles of every slot (the first tick), `bcd` is 0xF.
- R4: For the rest of the slot, `bcd` shows the low nibble of the entry addressed by `scan`, sampled at the end of the blank tick. A write during the slot changes nothing shown until that digit's next slot.
- R5: A command is a transfer with `wr_is_cmd`=1. If bit 7 is 1, the command is a clear. Otherwise, bit 0 selects the mode (0 = right-entry, 1 = left-entry) and the left pointer is reset to address 0.
- R6: In right-entry mode, a data write stores the byte at address 15 and moves entry i+1 to entry i. The old entry 0 is lost.
- R7: In left-entry mode, a data write stores the byte at the pointer and then moves the pointer up by one, wrapping from 15 to 0.
- R8: A clear writes 0xFF to all 16 entries, one per cycle. `wr_ready` is low for exactly 16 cycles after the clear is accepted. The clear resets the left pointer to 0 and keeps the current mode.
- R9: A write held while `wr_ready` is low is accepted exactly once, after `wr_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Block can accept a write |
| wr_is_cmd | input | 1 | 1 = command, 0 = digit data |
| wr_data | input | 8 | Command word or digit byte |
| scan | output | 4 | Current digit select |
| bcd | output | 4 | BCD code for the selected digit, 0xF = blank |

## Verification
The bench writes a digit in the middle of a slot. A design that tears would change the digit on the bus before the slot ends. The bench also offers a digit write during a clear sweep. A design that ignores back-pressure would lose that digit or store it twice. The bench writes 17 digits in left-entry mode to reach the pointer wrap; a design with a wrong wrap would overwrite address 0 with the wrong digit, or none at all. Random right-entry runs check the shift direction and that the digit leaving address 0 is discarded. Every frame is also checked for the blank tick and for a scan that steps evenly.

// File: rtl/bcd_disp_pkg.sv
package bcd_disp_pkg;
  typedef enum logic {
    ENTRY_RIGHT = 1'b0,
    ENTRY_LEFT  = 1'b1
  } entry_mode_e;
  localparam int unsigned CMD_CLEAR_BIT = 7;
  localparam int unsigned CMD_MODE_BIT  = 0;
endpackage

// File: rtl/bcd_tick_gen.sv
module bcd_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_scan_seq.sv
module bcd_scan_seq #(
  parameter int unsigned SLOT_TICKS = 4,
  parameter int unsigned AW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [AW-1:0] scan,
  output logic          cap_stb,
  output logic          wrap_stb
);
  localparam int unsigned PW = $clog2(SLOT_TICKS);
  logic [PW-1:0] ph_q;
  logic [AW-1:0] scan_q;

  assign cap_stb  = tick && (ph_q == '0);
  assign wrap_stb = tick && (ph_q == PW'(SLOT_TICKS - 1));
  assign scan     = scan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      scan_q <= '0;
    end else if (wrap_stb) begin
      ph_q   <= '0;
      scan_q <= scan_q + 1'b1;
    end else if (tick) begin
      ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_digit_store.sv
module bcd_digit_store
  import bcd_disp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned NIB   = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_is_cmd,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [NIB-1:0] rd_nib
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] clr_q;
  logic          clearing_q;
  entry_mode_e   mode_q;
  logic          xfer;

  assign wr_ready = !clearing_q;
  assign xfer     = wr_valid && wr_ready;
  assign rd_nib   = mem_q[rd_addr][NIB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      ptr_q      <= '0;
      clr_q      <= '0;
      clearing_q <= 1'b0;
      mode_q     <= ENTRY_RIGHT;
    end else if (clearing_q) begin
      mem_q[clr_q] <= '1;
      clr_q        <= clr_q + 1'b1;
      if (clr_q == AW'(DEPTH - 1)) clearing_q <= 1'b0;
    end else if (xfer) begin
      if (wr_is_cmd) begin
        ptr_q <= '0;
        if (wr_data[CMD_CLEAR_BIT]) begin
          clearing_q <= 1'b1;
          clr_q      <= '0;
        end else begin
          mode_q <= entry_mode_e'(wr_data[CMD_MODE_BIT]);
        end
      end else if (mode_q == ENTRY_LEFT) begin
        mem_q[ptr_q] <= wr_data;
        ptr_q <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end else begin
        for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
        mem_q[DEPTH-1] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned W          = 8,
  parameter int unsigned NIB        = 4,
  parameter int unsigned TICK_DIV   = 2,
  parameter int unsigned SLOT_TICKS = 4,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic           wr_is_cmd,
  input  logic [W-1:0]   wr_data,
  output logic [AW-1:0]  scan,
  output logic [NIB-1:0] bcd
);
  logic           tick, cap_stb, wrap_stb;
  logic [NIB-1:0] rd_nib;
  logic [NIB-1:0] bcd_q;

  bcd_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  bcd_scan_seq #(.SLOT_TICKS(SLOT_TICKS), .AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .scan(scan), .cap_stb(cap_stb), .wrap_stb(wrap_stb)
  );

  bcd_digit_store #(.DEPTH(DEPTH), .W(W), .NIB(NIB)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_is_cmd(wr_is_cmd), .wr_data(wr_data),
    .rd_addr(scan), .rd_nib(rd_nib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        bcd_q <= '1;
    else if (wrap_stb) bcd_q <= '1;
    else if (cap_stb)  bcd_q <= rd_nib;
  end

  assign bcd = bcd_q;
endmodule

// File: rtl/bcd_scan_display_chk.sv
module bcd_scan_display_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NIB   = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic           wr_is_cmd,
  input logic           clr_bit,
  input logic [AW-1:0]  scan,
  input logic [NIB-1:0] bcd
);
  logic [AW:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         low_run <= '0;
    else if (!wr_ready) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan) |-> scan == AW'($past(scan) + 1'b1));

  p_blank_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan) |-> bcd == '1);

  p_no_tear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bcd) && $stable(scan)) |-> $past(bcd) == '1);

  p_clear_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_is_cmd && clr_bit) |=> !wr_ready);

  p_stall_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (AW+1)'(DEPTH));
endmodule

bind bcd_scan_display bcd_scan_display_chk #(.DEPTH(DEPTH), .NIB(NIB)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_is_cmd(wr_is_cmd), .clr_bit(wr_data[7]), .scan(scan), .bcd(bcd)
);

// File: tb/bcd_scan_display_tb_top.sv
module bcd_scan_display_tb_top;
  localparam int DEPTH = 16, TICK_DIV = 2, SLOT_TICKS = 4;
  localparam int SLOT_CLKS = TICK_DIV * SLOT_TICKS;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_is_cmd = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready;
  logic [3:0] scan, bcd;

  int checks = 0, errors = 0;
  logic [7:0] m_mem [DEPTH];
  int m_ptr = 0;
  bit m_left = 0;

  always #2 clk = ~clk;

  bcd_scan_display #(.DEPTH(DEPTH), .TICK_DIV(TICK_DIV), .SLOT_TICKS(SLOT_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_is_cmd(wr_is_cmd), .wr_data(wr_data), .scan(scan), .bcd(bcd)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    m_ptr = 0; m_left = 0;
  endfunction

  function automatic void model_apply(bit is_cmd, logic [7:0] d);
    if (is_cmd) begin
      m_ptr = 0;
      if (d[7]) for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      else m_left = d[0];
    end else if (m_left) begin
      m_mem[m_ptr] = d;
      m_ptr = (m_ptr + 1) % DEPTH;
    end else begin
      for (int i = 0; i < DEPTH - 1; i++) m_mem[i] = m_mem[i+1];
      m_mem[DEPTH-1] = d;
    end
  endfunction

  task automatic host_write(bit is_cmd, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_is_cmd = is_cmd; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    model_apply(is_cmd, d);
  endtask

  task automatic wait_frame_start();
    logic [3:0] prev;
    do begin
      prev = scan;
      @(negedge clk);
    end while (!(prev != 0 && scan == 0));
  endtask

  task automatic check_frame(string tag);
    wait_frame_start();
    for (int k = 0; k < DEPTH; k++) begin
      chk({tag, " R2 scan"}, scan, k);
      chk({tag, " R3 blank"}, bcd, 4'hF);
      repeat (SLOT_CLKS - 1) @(negedge clk);
      chk({tag, " R4 digit"}, bcd, m_mem[k][3:0]);
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    logic [3:0] held;
    void'($urandom(32'd2024));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 scan", scan, 0);
    chk("R1 bcd", bcd, 4'hF);
    chk("R1 ready", wr_ready, 1);
    check_frame("R1");

    // R6 right-entry directed: 17 digits, first falls off
    for (int i = 0; i < 17; i++) host_write(0, 8'(i % 10));
    check_frame("R6");

    // R7 left-entry with wrap
    host_write(1, 8'h01);
    for (int i = 0; i < 17; i++) host_write(0, 8'((i + 3) % 10));
    check_frame("R7");

    // R8 clear: count stall cycles, mode kept
    host_write(1, 8'h80);
    lows = 0;
    while (!wr_ready && lows < 100) begin lows++; @(negedge clk); end
    chk("R8 stall cycles", lows, DEPTH);
    host_write(0, 8'h05);
    check_frame("R8");

    // R9 write held during clear sweep
    host_write(1, 8'h00);
    host_write(1, 8'h80);
    host_write(0, 8'h07);
    check_frame("R9");

    // R4 no tearing: write in mid-slot
    for (int i = 0; i < DEPTH; i++) host_write(0, 8'(i % 9));
    wait_frame_start();
    repeat (5 * SLOT_CLKS + TICK_DIV + 1) @(negedge clk);
    held = bcd;
    host_write(0, 8'h09);
    while (scan == 5 && bcd == held) @(negedge clk);
    chk("R4 no tear scan", scan, 6);
    check_frame("R4 after");

    // R5 mode command resets pointer; random mix
    for (int r = 0; r < 12; r++) begin
      for (int j = 0; j < 25; j++) begin
        int p = $urandom % 20;
        if (p == 0)      host_write(1, 8'(($urandom % 2) | 8'h40));
        else if (p == 1) host_write(1, 8'h80);
        else             host_write(0, 8'($urandom));
      end
      check_frame("R5 R6 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule